// File: doc/BRIEF.md
# Bit Access Unit for Byte-Wide Data Memory

This unit lets an instruction decoder treat a byte-organised data memory as an array of single bits. The decoder hands over a 10-bit bit index, an operation code, a displacement byte and the current program counter. The unit turns the index into a byte address and a bit position, then reads that byte through a byte-wide direct memory port. It reports the bit and, for set and clear, writes the changed byte back.

The lower half of the bit index space covers ordinary data bytes. The upper half covers a separate window of special-function-register bytes that starts at byte 0x400. The test-and-branch operation also returns a taken flag and a halfword-aligned target, so the decoder can redirect fetch.

Each request takes a fixed three-cycle sequence. While the unit is busy, no other memory access can come between its read and its write.

Top module: `bit_access_unit`

## Requirements
- R1: The bit index is `{req_opc_lo[1:0], req_bit_lo[7:0]}`: the two opcode bits form index bits 9:8 and the operand byte forms bits 7:0.
- R2: An index below 0x200 addresses data byte (index >> 3), in the range 0x000 to 0x03F.
- R3: An index of 0x200 or above addresses byte 0x400 + ((index - 0x200) >> 3), in the register window 0x400 to 0x43F.
- R4: The bit position is (index mod 8). In the done cycle, `bit_value` shows the value that bit had when the byte was read.
- R5: With `req_op` = 2'b01 (set), the byte written back equals the byte read, OR the single-bit mask. No other bit changes.
- R6: With `req_op` = 2'b10 (clear), the byte written back equals the byte read, AND the inverted single-bit mask.
- R7: With `req_op` = 2'b00 (read) or 2'b11 (test-and-branch), memory is never written.
- R8: Timing of an accepted request:
  - A request is accepted on a clock edge where `req_valid` is high and `busy` is low.
  - `mem_rd` is high for exactly the next cycle.
  - In the cycle after that, `mem_wr` is high at the same address, but only for set and clear.
  - `done` pulses for one cycle after that. `busy` is high for the two cycles between acceptance and `done`.
  - A request presented while `busy` is high is ignored.
- R9: `br_taken` is high in the done cycle only when the operation is test-and-branch and the tested bit read as 1. Otherwise it is low.
- R10: `br_target` in the done cycle equals (pc + 2 × sign-extended displacement) modulo 2^24, with bit 0 forced to 0.
- R11: After synchronous reset, `busy`, `done`, `mem_rd`, `mem_wr` and `br_taken` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 read, 01 set, 10 clear, 11 test-and-branch |
| req_opc_lo | input | 2 | Opcode low bits, bit index 9:8 |
| req_bit_lo | input | 8 | Operand byte, bit index 7:0 |
| req_disp | input | 8 | Signed branch displacement in halfwords |
| req_pc | input | 24 | Program counter the displacement is added to |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| bit_value | output | 1 | Prior value of the addressed bit |
| br_taken | output | 1 | Branch taken flag |
| br_target | output | 24 | Branch target |
| mem_addr | output | 11 | Byte address to memory |
| mem_rd | output | 1 | Memory read strobe; data returns the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Byte written back |
| mem_rdata | input | 8 | Byte returned by memory |

## Verification
The hardest case to reach from the ports is a new request that arrives while the unit is still busy, or in the very done cycle of the previous one. Only the first must be accepted, and the second must see the byte the first one wrote.

The bench holds `req_valid` high across a whole sequence while changing the operands. It also issues requests back to back, starting each in the done cycle of the one before. The reference model predicts which request is accepted and what the memory holds. The bench also sends indices at 0x1FF, 0x200 and 0x3FF, displacements of 0x7F and 0x80, and program counters near the 24-bit wrap.

// File: rtl/bitmem_pkg.sv
package bitmem_pkg;

    parameter int BIT_IDX_W  = 10;
    parameter int DATA_W     = 8;
    parameter int MEM_ADDR_W = 11;
    parameter int PC_W       = 24;
    parameter int DISP_W     = 8;
    parameter logic [MEM_ADDR_W-1:0] REG_WIN_BASE = 11'h400;

    localparam int POS_W   = $clog2(DATA_W);
    localparam int OFS_W   = BIT_IDX_W - 1 - POS_W;
    localparam int OPC_W   = BIT_IDX_W - 8;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_SET    = 2'b01,
        OP_CLEAR  = 2'b10,
        OP_TESTBR = 2'b11
    } bit_op_e;

    typedef struct packed {
        logic                  in_reg_win;
        logic [MEM_ADDR_W-1:0] byte_addr;
        logic [POS_W-1:0]      pos;
    } bit_loc_t;

    typedef struct packed {
        bit_op_e         op;
        bit_loc_t        loc;
        logic [PC_W-1:0] target;
    } bit_ctx_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FETCH = 2'b01,
        ST_WRITE = 2'b10
    } seq_state_e;

    function automatic logic op_writes(input bit_op_e op);
        return (op == OP_SET) || (op == OP_CLEAR);
    endfunction

endpackage

// File: rtl/bitmem_addr_map.sv
module bitmem_addr_map
    import bitmem_pkg::*;
(
    input  logic [OPC_W-1:0] opc_lo,
    input  logic [7:0]       bit_lo,
    output bit_loc_t         loc
);
    logic [BIT_IDX_W-1:0] idx;
    logic [OFS_W-1:0]     ofs;

    always_comb begin
        idx            = {opc_lo, bit_lo};
        ofs            = idx[BIT_IDX_W-2:POS_W];
        loc.in_reg_win = idx[BIT_IDX_W-1];
        loc.pos        = idx[POS_W-1:0];
        loc.byte_addr  = (loc.in_reg_win ? REG_WIN_BASE : '0) + MEM_ADDR_W'(ofs);
    end
endmodule

// File: rtl/bitmem_branch_calc.sv
module bitmem_branch_calc
    import bitmem_pkg::*;
(
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   target
);
    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] sum;

    always_comb begin
        disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
        sum      = pc + (disp_ext << 1);
        target   = {sum[PC_W-1:1], 1'b0};
    end
endmodule

// File: rtl/bitmem_seq.sv
module bitmem_seq
    import bitmem_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept,
    input  bit_ctx_t              ctx_in,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [MEM_ADDR_W-1:0] mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  busy,
    output logic                  done,
    output logic                  bit_value,
    output logic                  br_taken,
    output logic [PC_W-1:0]       br_target
);
    seq_state_e        state;
    bit_ctx_t          ctx;
    logic              cur_bit;
    logic              new_val;
    logic [DATA_W-1:0] merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctx       <= '0;
            done      <= 1'b0;
            bit_value <= 1'b0;
            br_taken  <= 1'b0;
            br_target <= '0;
        end else begin
            done     <= 1'b0;
            br_taken <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    ctx   <= ctx_in;
                    state <= ST_FETCH;
                end
                ST_FETCH: state <= ST_WRITE;
                ST_WRITE: begin
                    state     <= ST_IDLE;
                    done      <= 1'b1;
                    bit_value <= cur_bit;
                    br_taken  <= (ctx.op == OP_TESTBR) && cur_bit;
                    br_target <= ctx.target;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cur_bit = mem_rdata[ctx.loc.pos];
    assign new_val = (ctx.op == OP_SET);

    for (genvar g = 0; g < DATA_W; g++) begin : g_merge
        assign merged[g] = (ctx.loc.pos == POS_W'(g)) ? new_val : mem_rdata[g];
    end

    assign busy      = (state != ST_IDLE);
    assign mem_addr  = ctx.loc.byte_addr;
    assign mem_rd    = (state == ST_FETCH);
    assign mem_wr    = (state == ST_WRITE) && op_writes(ctx.op);
    assign mem_wdata = merged;

    assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd));
    assert_addr_held_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $stable(mem_addr));
    assert_single_rd_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_one_bit_change_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($countones(mem_wdata ^ mem_rdata) <= 1));
    assert_taken_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> done);
    assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !br_taken));
endmodule

// File: rtl/bit_access_unit.sv
module bit_access_unit
    import bitmem_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [OPC_W-1:0]      req_opc_lo,
    input  logic [7:0]            req_bit_lo,
    input  logic [DISP_W-1:0]     req_disp,
    input  logic [PC_W-1:0]       req_pc,
    output logic                  busy,
    output logic                  done,
    output logic                  bit_value,
    output logic                  br_taken,
    output logic [PC_W-1:0]       br_target,
    output logic [MEM_ADDR_W-1:0] mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata
);
    bit_loc_t        loc;
    logic [PC_W-1:0] tgt;
    bit_ctx_t        ctx;
    logic            accept;

    bitmem_addr_map u_map (
        .opc_lo (req_opc_lo),
        .bit_lo (req_bit_lo),
        .loc    (loc)
    );

    bitmem_branch_calc u_br (
        .pc     (req_pc),
        .disp   (req_disp),
        .target (tgt)
    );

    assign accept     = req_valid && !busy;
    assign ctx.op     = bit_op_e'(req_op);
    assign ctx.loc    = loc;
    assign ctx.target = tgt;

    bitmem_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .ctx_in    (ctx),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .bit_value (bit_value),
        .br_taken  (br_taken),
        .br_target (br_target)
    );

    assert_reg_window_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && req_opc_lo[OPC_W-1]) |=> (mem_addr >= REG_WIN_BASE));
    assert_data_window_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_opc_lo[OPC_W-1]) |=> (mem_addr < REG_WIN_BASE));
    assert_no_write_ro_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_op == 2'b00 || req_op == 2'b11)) |=> ##1 !mem_wr);
endmodule

// File: tb/tb_bit_access_unit.sv
module tb_bit_access_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [1:0]  req_opc_lo = 2'b00;
    logic [7:0]  req_bit_lo = 8'h00;
    logic [7:0]  req_disp = 8'h00;
    logic [23:0] req_pc = 24'h0;
    logic        busy, done, bit_value, br_taken, mem_rd, mem_wr;
    logic [23:0] br_target;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] ram     [2048];
    logic [7:0] ref_mem [2048];

    always #5 clk = ~clk;

    bit_access_unit dut (.*);

    always @(posedge clk) begin
        if (mem_wr) ram[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= ram[mem_addr];
    end

    // reference model state
    int          ph = 0;
    int          m_op;
    int          m_addr;
    int          m_pos;
    logic        m_old;
    logic [7:0]  m_wdata;
    logic [23:0] m_tgt;

    always @(posedge clk) begin
        if (rst) ph = 0;
        else begin
            case (ph)
                1: ph = 2;
                2: begin
                    if (m_op == 1 || m_op == 2) ref_mem[m_addr] = m_wdata;
                    ph = 3;
                end
                default: begin
                    if (req_valid) begin
                        int idx;
                        int d;
                        idx = req_opc_lo * 256 + req_bit_lo;
                        m_op = req_op;
                        if (idx < 512) m_addr = idx / 8;
                        else m_addr = 1024 + (idx - 512) / 8;
                        m_pos = idx % 8;
                        m_old = ref_mem[m_addr][m_pos];
                        if (m_op == 1) m_wdata = ref_mem[m_addr] | (8'h1 << m_pos);
                        else m_wdata = ref_mem[m_addr] & ~(8'h1 << m_pos);
                        d = (req_disp > 127) ? req_disp - 256 : req_disp;
                        m_tgt = 24'(req_pc + 2 * d) & 24'hFFFFFE;
                        ph = 1;
                    end else ph = 0;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R8 busy", 32'(busy), 32'(ph == 1 || ph == 2));
            chk("R8 done", 32'(done), 32'(ph == 3));
            chk("R8 mem_rd", 32'(mem_rd), 32'(ph == 1));
            if (ph == 2 && (m_op == 0 || m_op == 3)) chk("R7 mem_wr", 32'(mem_wr), 0);
            else chk("R8 mem_wr", 32'(mem_wr), 32'(ph == 2));
            if (ph == 1 || ph == 2) begin
                if (m_addr < 1024) chk("R1,R2 addr", 32'(mem_addr), 32'(m_addr));
                else chk("R1,R3 addr", 32'(mem_addr), 32'(m_addr));
            end
            if (ph == 2 && m_op == 1) chk("R5 wdata", 32'(mem_wdata), 32'(m_wdata));
            if (ph == 2 && m_op == 2) chk("R6 wdata", 32'(mem_wdata), 32'(m_wdata));
            if (ph == 3) begin
                chk("R4 bit_value", 32'(bit_value), 32'(m_old));
                chk("R9 taken", 32'(br_taken), 32'(m_op == 3 && m_old));
                if (m_op == 3) chk("R10 target", 32'(br_target), 32'(m_tgt));
            end else chk("R9 taken idle", 32'(br_taken), 0);
        end
    end

    task automatic issue(input logic [1:0] op, input logic [1:0] opc, input logic [7:0] lo,
                         input logic [7:0] disp, input logic [23:0] pc);
        req_valid = 1'b1; req_op = op; req_opc_lo = opc; req_bit_lo = lo;
        req_disp = disp; req_pc = pc;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            ram[i] = 8'((i * 37 + 5) & 8'hFF);
            ref_mem[i] = 8'((i * 37 + 5) & 8'hFF);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: idle after reset
        chk("R11 busy", 32'(busy), 0);
        chk("R11 done", 32'(done), 0);
        chk("R11 mem_rd", 32'(mem_rd), 0);
        chk("R11 mem_wr", 32'(mem_wr), 0);
        chk("R11 br_taken", 32'(br_taken), 0);
        // directed: region edges, set/clear/read, R1 via opcode bits
        issue(2'b01, 2'b00, 8'h00, 8'h00, 24'h0);
        issue(2'b10, 2'b00, 8'h00, 8'h00, 24'h0);
        issue(2'b01, 2'b01, 8'hFF, 8'h00, 24'h0);
        issue(2'b01, 2'b10, 8'h00, 8'h00, 24'h0);
        issue(2'b10, 2'b11, 8'hFF, 8'h00, 24'h0);
        issue(2'b00, 2'b10, 8'h00, 8'h00, 24'h0);
        issue(2'b00, 2'b11, 8'hFF, 8'h00, 24'h0);
        // R9/R10: taken and not taken, displacement signs, wrap
        issue(2'b01, 2'b00, 8'h13, 8'h00, 24'h0);
        issue(2'b11, 2'b00, 8'h13, 8'h7F, 24'h001000);
        issue(2'b10, 2'b00, 8'h13, 8'h00, 24'h0);
        issue(2'b11, 2'b00, 8'h13, 8'h80, 24'h001000);
        issue(2'b01, 2'b10, 8'h45, 8'h00, 24'h0);
        issue(2'b11, 2'b10, 8'h45, 8'h10, 24'hFFFFF1);
        issue(2'b11, 2'b10, 8'h45, 8'hF0, 24'h000003);
        // R8: request held high while busy, operands changing
        req_valid = 1'b1; req_op = 2'b01; req_opc_lo = 2'b00; req_bit_lo = 8'h21;
        @(negedge clk); req_op = 2'b10; req_bit_lo = 8'h22;
        @(negedge clk); req_op = 2'b01; req_bit_lo = 8'h23;
        @(negedge clk); req_op = 2'b00; req_bit_lo = 8'h21;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        // random back-to-back traffic
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            issue(r[1:0], r[3:2], r[11:4], r[19:12], {r[31:20], r[11:0]});
        end
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 2048; i++)
            if (ram[i] !== ref_mem[i]) chk("R5,R6 mem", 32'(ram[i]), 32'(ref_mem[i]));
        chk("R8 final idle", 32'(busy), 0);
        report();
    end
endmodule